// File: doc/BRIEF.md
# Analog Monitor Presence Probe

This block decides whether an analog display is attached to a video output. It works by loading the output lines and watching a comparator. A single start pulse launches a fixed control sequence. The block first records the current output-select word and the DAC control word. It then powers the DAC and blanks every output. After a settle delay it turns only the analog output back on. It programs a mid-scale test pattern on the three colour channels and routes that pattern to the output. After a second settle delay it samples the comparator that reports whether every colour path is loaded.

Once the sample is taken, the block removes the test routing and writes both recorded words back. It then reports the outcome with a one-cycle done pulse and a present bit. While the sequence runs, the block drives three register-style output words, each with a one-cycle write strobe. The surrounding register file applies each value on its strobe. The comparator itself sits outside the block and arrives as a single input.

Top module: `crt_load_probe`

## Requirements
- R1: After reset, done and present are low, no write strobe is active, and all three driven words are zero.
- R2: On the start edge the block records outSelCur and dacCtrlCur. The two final write-backs use exactly these recorded values, even if the inputs change later.
- R3: The first write of the sequence goes to the DAC control word. Its value is the recorded word with bit 16 cleared, which powers the DAC. The DAC stays powered while the test pattern is loaded.
- R4: The second write goes to the output-select word. Its value is the recorded word ANDed with 0x0000FEEE, which blanks the outputs and deselects the head.
- R5: The analog output is re-enabled SETTLE_CYCLES+1 cycles after the blanking write, by writing the blanked word with bit 0 set.
- R6: The next write loads the test-pattern word 0x94050140. Bits 31:30 hold mode 2, and bits 29:20, 19:10 and 9:0 each hold level 0x140.
- R7: The next write sets bit 12 of the DAC control word to route the test signal. The comparator is sampled SETTLE_CYCLES+1 cycles after that write.
- R8: present equals the value of allPathsLoaded at the sample edge. Levels on allPathsLoaded before the sample edge have no effect.
- R9: After the sample, the block writes the DAC control word with bit 12 cleared. It then restores the output-select word, and then restores the DAC control word. The sequence has exactly eight writes in total.
- R10: done is a one-cycle pulse in the cycle of the final restore, 9+2*SETTLE_CYCLES cycles after the start edge. present is valid in that same cycle and is held until the next done.
- R11: A start pulse that arrives while a sequence is running is ignored. It triggers no extra writes and no second done.
- R12: At most one write strobe is active in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | Launches a probe when the block is idle |
| outSelCur | input | 32 | Present output-select register value |
| dacCtrlCur | input | 32 | Present DAC control register value |
| allPathsLoaded | input | 1 | Comparator result: every colour path is loaded |
| outSelValue | output | 32 | Output-select word to write |
| outSelWe | output | 1 | Write strobe for outSelValue |
| dacCtrlValue | output | 32 | DAC control word to write |
| dacCtrlWe | output | 1 | Write strobe for dacCtrlValue |
| testPatValue | output | 32 | Test-pattern word to write |
| testPatWe | output | 1 | Write strobe for testPatValue |
| done | output | 1 | One-cycle completion pulse |
| present | output | 1 | Probe result: monitor attached |

## Verification
The bench builds the block with SETTLE_CYCLES set to 4. This keeps a full probe at 17 cycles, so the bench can sweep every combination of four register patterns and four comparator behaviours. Among these behaviours, one raises the comparator exactly one cycle before the sample edge, and one drops it just after the routing write. These two cases pin down the sample instant to the exact cycle. Each run also changes the register inputs right after start and fires a second start mid-sequence. This exercises the capture rule and the busy rule in every combination.

// File: rtl/crt_probe_pkg.sv
package crt_probe_pkg;
  localparam int WORD_W = 32;
  localparam int DAC_PWRDN_BIT = 16;
  localparam int DAC_ROUTE_BIT = 12;
  localparam int OUT_ANALOG_BIT = 0;
  localparam logic [WORD_W-1:0] BLANK_MASK = 32'h0000_FEEE;

  typedef enum logic [3:0] {
    ST_IDLE, ST_POWER, ST_BLANK, ST_SETTLE_A, ST_ENABLE, ST_PATTERN,
    ST_ROUTE, ST_SETTLE_B, ST_SAMPLE, ST_UNROUTE, ST_REST_OUT, ST_REST_DAC
  } probe_state_t;

  typedef struct packed {
    logic capture;
    logic powerDac;
    logic blank;
    logic enAnalog;
    logic loadPattern;
    logic routeTest;
    logic sample;
    logic unrouteTest;
    logic restoreOut;
    logic restoreDac;
  } probe_cmd_t;
endpackage

// File: rtl/crt_probe_timer.sv
module crt_probe_timer #(
  parameter int CYCLES = 50000
) (
  input  logic clk,
  input  logic rstN,
  input  logic load,
  input  logic tick,
  output logic expired
);
  localparam int CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(CYCLES - 1);

  logic [CNT_W-1:0] count;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
    end else if (load) begin
      count <= LOAD_VAL;
    end else if (tick && count != '0) begin
      count <= count - 1'b1;
    end
  end

  assign expired = (count == '0);
endmodule

// File: rtl/crt_probe_ctrl.sv
module crt_probe_ctrl
  import crt_probe_pkg::*;
#(
  parameter int SETTLE_CYCLES = 50000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startPulse,
  output probe_cmd_t cmd
);
  probe_state_t state, nextState;
  logic timerLoad, timerTick, timerExpired;

  crt_probe_timer #(.CYCLES(SETTLE_CYCLES)) u_timer (
    .clk(clk), .rstN(rstN), .load(timerLoad), .tick(timerTick),
    .expired(timerExpired)
  );

  always_comb begin
    nextState = state;
    cmd = '0;
    timerLoad = 1'b0;
    timerTick = 1'b0;
    unique case (state)
      ST_IDLE: if (startPulse) begin
        cmd.capture = 1'b1;
        nextState = ST_POWER;
      end
      ST_POWER: begin
        cmd.powerDac = 1'b1;
        nextState = ST_BLANK;
      end
      ST_BLANK: begin
        cmd.blank = 1'b1;
        timerLoad = 1'b1;
        nextState = ST_SETTLE_A;
      end
      ST_SETTLE_A: begin
        timerTick = 1'b1;
        if (timerExpired) nextState = ST_ENABLE;
      end
      ST_ENABLE: begin
        cmd.enAnalog = 1'b1;
        nextState = ST_PATTERN;
      end
      ST_PATTERN: begin
        cmd.loadPattern = 1'b1;
        nextState = ST_ROUTE;
      end
      ST_ROUTE: begin
        cmd.routeTest = 1'b1;
        timerLoad = 1'b1;
        nextState = ST_SETTLE_B;
      end
      ST_SETTLE_B: begin
        timerTick = 1'b1;
        if (timerExpired) nextState = ST_SAMPLE;
      end
      ST_SAMPLE: begin
        cmd.sample = 1'b1;
        nextState = ST_UNROUTE;
      end
      ST_UNROUTE: begin
        cmd.unrouteTest = 1'b1;
        nextState = ST_REST_OUT;
      end
      ST_REST_OUT: begin
        cmd.restoreOut = 1'b1;
        nextState = ST_REST_DAC;
      end
      ST_REST_DAC: begin
        cmd.restoreDac = 1'b1;
        nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end
endmodule

// File: rtl/crt_probe_datapath.sv
module crt_probe_datapath
  import crt_probe_pkg::*;
#(
  parameter int LEVEL_W = 10,
  parameter logic [LEVEL_W-1:0] TEST_LEVEL = 10'h140,
  parameter logic [1:0] TEST_MODE = 2'd2
) (
  input  logic              clk,
  input  logic              rstN,
  input  probe_cmd_t        cmd,
  input  logic [WORD_W-1:0] outSelCur,
  input  logic [WORD_W-1:0] dacCtrlCur,
  input  logic              allPathsLoaded,
  output logic [WORD_W-1:0] outSelValue,
  output logic              outSelWe,
  output logic [WORD_W-1:0] dacCtrlValue,
  output logic              dacCtrlWe,
  output logic [WORD_W-1:0] testPatValue,
  output logic              testPatWe,
  output logic              done,
  output logic              present
);
  localparam int PAT_W = 2 + 3 * LEVEL_W;
  localparam logic [PAT_W-1:0] PATTERN = {TEST_MODE, TEST_LEVEL, TEST_LEVEL, TEST_LEVEL};

  logic [WORD_W-1:0] savedOut, savedDac;
  logic sampled;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      savedOut <= '0;
      savedDac <= '0;
      sampled  <= 1'b0;
    end else begin
      if (cmd.capture) begin
        savedOut <= outSelCur;
        savedDac <= dacCtrlCur;
      end
      if (cmd.sample) sampled <= allPathsLoaded;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outSelValue <= '0;
      outSelWe    <= 1'b0;
    end else begin
      outSelWe <= 1'b0;
      if (cmd.blank) begin
        outSelValue <= savedOut & BLANK_MASK;
        outSelWe    <= 1'b1;
      end else if (cmd.enAnalog) begin
        outSelValue[OUT_ANALOG_BIT] <= 1'b1;
        outSelWe <= 1'b1;
      end else if (cmd.restoreOut) begin
        outSelValue <= savedOut;
        outSelWe    <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dacCtrlValue <= '0;
      dacCtrlWe    <= 1'b0;
    end else begin
      dacCtrlWe <= 1'b0;
      if (cmd.powerDac) begin
        dacCtrlValue <= savedDac;
        dacCtrlValue[DAC_PWRDN_BIT] <= 1'b0;
        dacCtrlWe <= 1'b1;
      end else if (cmd.routeTest) begin
        dacCtrlValue[DAC_ROUTE_BIT] <= 1'b1;
        dacCtrlWe <= 1'b1;
      end else if (cmd.unrouteTest) begin
        dacCtrlValue[DAC_ROUTE_BIT] <= 1'b0;
        dacCtrlWe <= 1'b1;
      end else if (cmd.restoreDac) begin
        dacCtrlValue <= savedDac;
        dacCtrlWe    <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      testPatValue <= '0;
      testPatWe    <= 1'b0;
    end else begin
      testPatWe <= cmd.loadPattern;
      if (cmd.loadPattern) testPatValue <= WORD_W'(PATTERN);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      done    <= 1'b0;
      present <= 1'b0;
    end else begin
      done <= cmd.restoreDac;
      if (cmd.restoreDac) present <= sampled;
    end
  end
endmodule

// File: rtl/crt_load_probe.sv
module crt_load_probe
  import crt_probe_pkg::*;
#(
  parameter int SETTLE_CYCLES = 50000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startPulse,
  input  logic [31:0] outSelCur,
  input  logic [31:0] dacCtrlCur,
  input  logic        allPathsLoaded,
  output logic [31:0] outSelValue,
  output logic        outSelWe,
  output logic [31:0] dacCtrlValue,
  output logic        dacCtrlWe,
  output logic [31:0] testPatValue,
  output logic        testPatWe,
  output logic        done,
  output logic        present
);
  probe_cmd_t cmd;

  crt_probe_ctrl #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .cmd(cmd)
  );

  crt_probe_datapath u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd),
    .outSelCur(outSelCur), .dacCtrlCur(dacCtrlCur),
    .allPathsLoaded(allPathsLoaded),
    .outSelValue(outSelValue), .outSelWe(outSelWe),
    .dacCtrlValue(dacCtrlValue), .dacCtrlWe(dacCtrlWe),
    .testPatValue(testPatValue), .testPatWe(testPatWe),
    .done(done), .present(present)
  );
endmodule

// File: rtl/crt_load_probe_checker.sv
module crt_load_probe_checker (
  input logic        clk,
  input logic        rstN,
  input logic [31:0] dacCtrlValue,
  input logic        outSelWe,
  input logic        dacCtrlWe,
  input logic [31:0] testPatValue,
  input logic        testPatWe,
  input logic        done,
  input logic        present
);
  AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({outSelWe, dacCtrlWe, testPatWe})); // R12

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R10

  AST_PRESENT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !done |=> $stable(present) || done); // R10

  AST_PATTERN_WORD: assert property (@(posedge clk) disable iff (!rstN)
    testPatWe |-> testPatValue == 32'h9405_0140); // R6

  AST_POWERED_AT_PATTERN: assert property (@(posedge clk) disable iff (!rstN)
    testPatWe |-> !dacCtrlValue[16]); // R3

  AST_ROUTE_AFTER_PATTERN: assert property (@(posedge clk) disable iff (!rstN)
    testPatWe |=> dacCtrlWe && dacCtrlValue[12]); // R7

  AST_DONE_WITH_RESTORE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> dacCtrlWe); // R9
endmodule

bind crt_load_probe crt_load_probe_checker u_checker (
  .clk(clk), .rstN(rstN), .dacCtrlValue(dacCtrlValue),
  .outSelWe(outSelWe), .dacCtrlWe(dacCtrlWe),
  .testPatValue(testPatValue), .testPatWe(testPatWe),
  .done(done), .present(present)
);

// File: tb/crt_load_probe_bench.sv
module crt_load_probe_bench;
  localparam int S = 4;
  localparam logic [31:0] PAT = 32'h9405_0140;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startPulse = 1'b0;
  logic [31:0] outSelCur = '0, dacCtrlCur = '0;
  logic allPathsLoaded = 1'b0;
  logic [31:0] outSelValue, dacCtrlValue, testPatValue;
  logic outSelWe, dacCtrlWe, testPatWe, done, present;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  crt_load_probe #(.SETTLE_CYCLES(S)) u_crt_load_probe (
    .clk(clk), .rstN(rstN), .startPulse(startPulse),
    .outSelCur(outSelCur), .dacCtrlCur(dacCtrlCur),
    .allPathsLoaded(allPathsLoaded),
    .outSelValue(outSelValue), .outSelWe(outSelWe),
    .dacCtrlValue(dacCtrlValue), .dacCtrlWe(dacCtrlWe),
    .testPatValue(testPatValue), .testPatWe(testPatWe),
    .done(done), .present(present)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  int logKind [16];
  logic [31:0] logVal [16];
  int logCyc [16];

  // kind: 0 output-select, 1 DAC control, 2 test pattern
  task automatic runProbe(input logic [31:0] o, input logic [31:0] d, input int mode);
    int nW, nDone, routeK, doneK;
    logic seenPresent, expPresent;
    int expKind [8];
    logic [31:0] expVal [8];
    string tag [8];
    nW = 0; nDone = 0; routeK = -1; doneK = -1; seenPresent = 1'b0;
    expPresent = (mode == 1 || mode == 2);
    outSelCur = o; dacCtrlCur = d;
    allPathsLoaded = (mode == 1 || mode == 3);
    @(negedge clk);
    startPulse = 1'b1;
    for (int k = 0; k < 40 + 2 * S; k++) begin
      @(negedge clk);
      startPulse = (k == 3);   // R11: second start while busy
      if (k == 0) begin outSelCur = ~o; dacCtrlCur = ~d; end
      if (nW < 16) begin
        if (outSelWe)  begin logKind[nW] = 0; logVal[nW] = outSelValue;  logCyc[nW] = k; end
        if (dacCtrlWe) begin logKind[nW] = 1; logVal[nW] = dacCtrlValue; logCyc[nW] = k; end
        if (testPatWe) begin logKind[nW] = 2; logVal[nW] = testPatValue; logCyc[nW] = k; end
      end
      if (outSelWe || dacCtrlWe || testPatWe) nW++;
      if (dacCtrlWe && dacCtrlValue[12] && routeK < 0) begin
        routeK = k;
        if (mode == 3) allPathsLoaded = 1'b0;
      end
      if (mode == 2 && routeK >= 0 && k == routeK + S) allPathsLoaded = 1'b1;
      if (done) begin nDone++; doneK = k; seenPresent = present; end
    end
    expKind = '{1, 0, 0, 2, 1, 1, 0, 1};
    expVal[0] = d & ~32'h0001_0000;
    expVal[1] = o & 32'h0000_FEEE;
    expVal[2] = (o & 32'h0000_FEEE) | 32'h1;
    expVal[3] = PAT;
    expVal[4] = (d & ~32'h0001_0000) | 32'h1000;
    expVal[5] = d & ~32'h0001_1000;
    expVal[6] = o;
    expVal[7] = d;
    tag = '{"R3", "R4", "R5", "R6", "R7", "R9", "R2", "R2"};
    chk(nW == 8, "R9 R11 write count", nW, 8);
    for (int i = 0; i < 8 && i < nW; i++) begin
      chk(logKind[i] == expKind[i] && logVal[i] === expVal[i], tag[i], logVal[i], expVal[i]);
    end
    if (nW >= 3) chk(logCyc[2] - logCyc[1] == S + 1, "R5 settle gap", logCyc[2] - logCyc[1], S + 1);
    chk(nDone == 1, "R10 R11 done count", nDone, 1);
    chk(doneK == 9 + 2 * S, "R10 done cycle", doneK, 9 + 2 * S);
    chk(seenPresent == expPresent, "R8 present at done", {31'b0, seenPresent}, {31'b0, expPresent});
    chk(present == expPresent, "R10 present held", {31'b0, present}, {31'b0, expPresent});
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] oPat [4];
    logic [31:0] dPat [4];
    oPat = '{32'h0, 32'hFFFF_FFFF, 32'hA5A5_1357, 32'h5A5A_EEEF};
    dPat = '{32'hFFFF_FFFF, 32'h0, 32'h0001_1000, 32'h3C3C_EFFF};
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(!done && !present, "R1 done/present", {30'b0, done, present}, 32'h0);
    chk(!outSelWe && !dacCtrlWe && !testPatWe, "R1 strobes",
        {29'b0, outSelWe, dacCtrlWe, testPatWe}, 32'h0);
    chk(outSelValue == 0 && dacCtrlValue == 0 && testPatValue == 0, "R1 words",
        outSelValue | dacCtrlValue | testPatValue, 32'h0);
    for (int p = 0; p < 4; p++)
      for (int m = 0; m < 4; m++)
        runProbe(oPat[p], dPat[(p + m) % 4], m);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule